// File: doc/BRIEF.md
# Stride Miss Prediction Table

This block watches the stream of cache misses and learns, per load instruction, whether the misses march through memory with a constant step. A small direct-mapped table is indexed by the low bits of the load's program counter. The upper counter bits are kept as a tag. Each entry remembers only the newest two miss addresses of its stream, so the step is the difference between them. When a third miss moves by that same non-zero step, the entry enters stride mode. It then offers prefetch addresses ahead of the demand stream, up to a fixed distance.

A small per-entry count records how many steps beyond the newest miss have already been requested. A new prefetch therefore always starts one step past the furthest address already sent, and no address is requested twice while the stride holds. Each further miss that keeps the step moves the demand point forward by one step and lowers the count by one. This opens exactly one new prefetch slot. A plain status pin reports whether the stream of the most recent miss is in stride mode. Downstream logic uses it to route non-stride streams to a separate correlation and filtering path.

Prefetch addresses leave on a valid/ready stream, at most one per cycle. Back-pressure rule: while `pf_ready` is low and no miss arrives, an offered address stays valid and unchanged. A miss event always takes effect at once and may retarget the offer to the stream that just missed. Consumers must therefore treat an offer as a hint that can be withdrawn by a miss.

Top module: `stride_miss_table`

## Requirements
- R1: While and right after reset, `pf_valid` and `stride_flag` are both low.
- R2: The entry is picked by `miss_pc[log2(ENTRIES)-1:0]`, and the remaining upper PC bits form its tag. A miss whose tag differs from the stored one, or that lands on an empty entry, reallocates the entry. The stream then starts over with one stored address, `stride_flag` low and no prefetch.
- R3: Two misses of a stream never confirm a stride. The third miss confirms it when its step from the previous miss equals the previous step. `stride_flag` is then high in the cycle after that miss.
- R4: Once confirmed with newest miss L and step S, the block offers L+S, L+2S, ... in order, one address per handshake (`pf_valid && pf_ready` at a rising edge).
- R5: No more than DEGREE (default 4) addresses beyond the newest miss are ever requested. After the DEGREE-th handshake, `pf_valid` stays low until a further miss.
- R6: A further miss that keeps the step lowers the requested-ahead count by one, saturating at zero. The next offered address is the newest miss plus (count+1)·S, so no address is offered twice.
- R7: A miss whose step differs from the stored step clears stride mode and the count: `stride_flag` and `pf_valid` go low.
- R8: A step of zero is never a stride. Repeated misses to one address leave `stride_flag` and `pf_valid` low.
- R9: With `pf_ready` low and no miss, an offered address holds `pf_valid` high and `pf_addr` stable. A handshake with no miss makes the next offer, if any, exactly one step further.
- R10: `stride_flag` and the prefetch stream follow the entry of the most recent miss. Returning to an earlier stride stream resumes its prefetching where its count left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss event is present this cycle |
| miss_pc | input | PC_W | Program counter of the missing load |
| miss_addr | input | ADDR_W | Missing data address |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | Consumer accepts the offered address |
| pf_addr | output | ADDR_W | Offered prefetch address |
| stride_flag | output | 1 | Stream of the latest miss is in stride mode |

## Verification
The embedded properties assume at most one miss per cycle and treat a miss as free to retarget the offer. The hold and step checks on the output stream therefore apply only to cycles with no miss. The bench keeps to this: during back-pressure it sends no miss until it lowers `pf_ready` on purpose to test retargeting. Every index of the table is swept, each with its own signed step, using misses spaced one cycle apart. Expected addresses are derived arithmetically from base, step and count.

// File: rtl/stride_pkg.sv
package stride_pkg;
  // How many miss addresses an entry currently holds
  typedef enum logic [1:0] {
    HIST_NONE = 2'd0,
    HIST_ONE  = 2'd1,
    HIST_TWO  = 2'd2
  } hist_e;
endpackage

// File: rtl/ppt_entry.sv
module ppt_entry
  import stride_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 12,
  parameter int DEGREE = 4,
  localparam int CNT_W = $clog2(DEGREE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic              fire,
  output hist_e             hist,
  output logic [TAG_W-1:0]  tag,
  output logic [ADDR_W-1:0] last,
  output logic [ADDR_W-1:0] stride,
  output logic              mode,
  output logic [CNT_W-1:0]  cnt
);
  logic [ADDR_W-1:0] last_q, prev_q, delta_new;
  logic [TAG_W-1:0]  tag_q;
  hist_e             hist_q;
  logic              mode_q, step_match;
  logic [CNT_W-1:0]  cnt_q, cnt_eff, cnt_dec;

  assign stride     = last_q - prev_q;
  assign delta_new  = new_addr - last_q;
  assign step_match = (delta_new == stride) && (stride != '0);
  assign cnt_eff    = cnt_q + CNT_W'(fire);
  assign cnt_dec    = (cnt_eff == '0) ? '0 : cnt_eff - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= HIST_NONE;
      tag_q  <= '0;
      last_q <= '0;
      prev_q <= '0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      if (alloc) begin
        hist_q <= HIST_ONE;
        tag_q  <= new_tag;
        last_q <= new_addr;
        prev_q <= new_addr;
        mode_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        prev_q <= last_q;
        last_q <= new_addr;
        hist_q <= HIST_TWO;
        if (hist_q == HIST_TWO && step_match) begin
          mode_q <= 1'b1;
          cnt_q  <= mode_q ? cnt_dec : '0;
        end else begin
          mode_q <= 1'b0;
          cnt_q  <= '0;
        end
      end
    end else if (fire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hist = hist_q;
  assign tag  = tag_q;
  assign last = last_q;
  assign mode = mode_q;
  assign cnt  = cnt_q;

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEGREE));

  // R8
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (last_q != prev_q));

  // R5
  fire_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (mode_q && cnt_q < CNT_W'(DEGREE)));
endmodule

// File: rtl/ppt_pf_gen.sv
module ppt_pf_gen #(
  parameter int ADDR_W = 32,
  parameter int DEGREE = 4,
  localparam int CNT_W = $clog2(DEGREE + 1)
) (
  input  logic              act_vld,
  input  logic              mode,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] last,
  input  logic [ADDR_W-1:0] stride,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  logic [ADDR_W-1:0] cnt_ext, ahead;

  assign cnt_ext  = ADDR_W'(cnt);
  assign ahead    = stride * cnt_ext;
  assign pf_valid = act_vld && mode && (cnt < CNT_W'(DEGREE));
  assign pf_addr  = last + ahead + stride;
endmodule

// File: rtl/stride_miss_table.sv
module stride_miss_table
  import stride_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int DEGREE  = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W,
  localparam int CNT_W  = $clog2(DEGREE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [PC_W-1:0]   miss_pc,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              stride_flag
);
  logic [IDX_W-1:0]  miss_idx, act_idx_q;
  logic [TAG_W-1:0]  miss_tag;
  logic              act_vld_q, fire, miss_alloc;

  hist_e             e_hist   [ENTRIES];
  logic [TAG_W-1:0]  e_tag    [ENTRIES];
  logic [ADDR_W-1:0] e_last   [ENTRIES];
  logic [ADDR_W-1:0] e_stride [ENTRIES];
  logic              e_mode   [ENTRIES];
  logic [CNT_W-1:0]  e_cnt    [ENTRIES];

  assign miss_idx   = miss_pc[IDX_W-1:0];
  assign miss_tag   = miss_pc[PC_W-1:IDX_W];
  assign miss_alloc = (e_hist[miss_idx] == HIST_NONE) || (e_tag[miss_idx] != miss_tag);
  assign fire       = pf_valid && pf_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic upd_g, fire_g;
    assign upd_g  = miss_valid && (miss_idx == IDX_W'(g));
    assign fire_g = fire && (act_idx_q == IDX_W'(g));

    ppt_entry #(
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W),
      .DEGREE (DEGREE)
    ) entry_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd_g),
      .alloc    (miss_alloc),
      .new_tag  (miss_tag),
      .new_addr (miss_addr),
      .fire     (fire_g),
      .hist     (e_hist[g]),
      .tag      (e_tag[g]),
      .last     (e_last[g]),
      .stride   (e_stride[g]),
      .mode     (e_mode[g]),
      .cnt      (e_cnt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_vld_q <= 1'b0;
      act_idx_q <= '0;
    end else if (miss_valid) begin
      act_vld_q <= 1'b1;
      act_idx_q <= miss_idx;
    end
  end

  ppt_pf_gen #(
    .ADDR_W (ADDR_W),
    .DEGREE (DEGREE)
  ) gen_i (
    .act_vld  (act_vld_q),
    .mode     (e_mode[act_idx_q]),
    .cnt      (e_cnt[act_idx_q]),
    .last     (e_last[act_idx_q]),
    .stride   (e_stride[act_idx_q]),
    .pf_valid (pf_valid),
    .pf_addr  (pf_addr)
  );

  assign stride_flag = act_vld_q && e_mode[act_idx_q];

  // R9
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !miss_valid) |=> (pf_valid && $stable(pf_addr)));

  // R9
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !miss_valid) |=>
      (!pf_valid || (pf_addr - $past(pf_addr) == e_stride[act_idx_q])));

  // R2
  realloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_alloc) |=> (!stride_flag && !pf_valid));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!pf_valid && !stride_flag));
endmodule

// File: tb/stride_miss_table_tb.sv
module stride_miss_table_tb_top;
  localparam int PC_W = 16, ADDR_W = 32, ENTRIES = 16, DEGREE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              miss_valid = 1'b0;
  logic [PC_W-1:0]   miss_pc = '0;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic              pf_valid, pf_ready, stride_flag;
  logic [ADDR_W-1:0] pf_addr;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stride_miss_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .DEGREE(DEGREE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc),
    .miss_addr(miss_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .stride_flag(stride_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic miss(input logic [15:0] pc, input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1; miss_pc = pc; miss_addr = a;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic expect_pf(input logic [31:0] exp, input string req);
    check(pf_valid && pf_addr == exp, req, pf_valid ? pf_addr : 32'hdead_0000, exp);
    @(negedge clk);
  endtask

  task automatic expect_idle(input string req);
    check(!pf_valid, req, {31'd0, pf_valid}, 32'd0);
  endtask

  task automatic expect_flag(input bit exp, input string req);
    check(stride_flag == exp, req, {31'd0, stride_flag}, {31'd0, exp});
  endtask

  function automatic logic [31:0] at(input logic [31:0] b, input int s, input int k);
    return b + 32'(s * k);
  endfunction

  function automatic int step_of(input int i);
    int sv[8] = '{1, 2, 7, -1, -5, 64, -64, 1000};
    return sv[i % 8] * ((i >= 8) ? 3 : 1);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pc;
    logic [31:0] b;
    int s;
    pf_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_idle("R1");
    expect_flag(1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R1");

    for (int i = 0; i < ENTRIES; i++) begin
      pc = 16'(((i + 5) << 4) | i);
      b  = 32'h1000_0000 + 32'(i) * 32'h0010_0000;
      s  = step_of(i);
      miss(pc, b);
      expect_flag(1'b0, "R2"); expect_idle("R2");
      miss(pc, at(b, s, 1));
      expect_flag(1'b0, "R3"); expect_idle("R3");
      miss(pc, at(b, s, 2));
      expect_flag(1'b1, "R3");
      for (int k = 1; k <= DEGREE; k++) expect_pf(at(b, s, 2 + k), "R4");
      expect_idle("R5");
      miss(pc, at(b, s, 3));
      expect_flag(1'b1, "R6");
      expect_pf(at(b, s, 7), "R6");
      expect_idle("R6");
      miss(pc, at(b, s, 4) + 32'd1);
      expect_flag(1'b0, "R7"); expect_idle("R7");
    end

    // R2 reallocation with a new tag, R8 zero step
    pc = 16'h7770;
    b  = 32'h4000_0000;
    miss(pc, b);
    expect_flag(1'b0, "R2"); expect_idle("R2");
    miss(pc, b);
    miss(pc, b);
    expect_flag(1'b0, "R8"); expect_idle("R8");
    miss(pc, b);
    expect_flag(1'b0, "R8"); expect_idle("R8");

    // R9 back-pressure holds the offer
    pc = 16'h5553;
    b  = 32'h5000_0000;
    pf_ready = 1'b0;
    miss(pc, b); miss(pc, b + 32'd16); miss(pc, b + 32'd32);
    for (int k = 0; k < 3; k++) begin
      check(pf_valid && pf_addr == b + 32'd48, "R9", pf_addr, b + 32'd48);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    expect_pf(b + 32'd48, "R9");
    expect_pf(b + 32'd64, "R9");
    pf_ready = 1'b0;
    // R10 another stream takes over, then the first resumes
    miss(16'h6665, 32'h6000_0000);
    expect_flag(1'b0, "R10"); expect_idle("R10");
    miss(pc, b + 32'd48);
    expect_flag(1'b1, "R10");
    pf_ready = 1'b1;
    expect_pf(b + 32'd80, "R10");
    expect_pf(b + 32'd96, "R10");
    expect_pf(b + 32'd112, "R10");
    expect_idle("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule